// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Dead Time

This block drives the four gate commands of a single H-bridge. Each of the two output legs has a high-side and a low-side switch. Two PWM direction inputs choose forward, reverse, short brake or coast. A pair of enable inputs gates the whole bridge. The inputs are synchronized to a fixed internal clock and decoded into a target state per leg.

Each leg then moves toward its target under two rules. A switch may turn off at once. A switch may turn on only after the leg has spent a programmable dead interval with both of its switches off. A high-side switch also turns on only while the opposite leg is already held on its low side. This rule makes every change of direction pass through a short-brake interval.

Protection logic can override the inputs. A force-off input clears all four gates in one cycle. A force-brake input steers both legs to their low-side switches through the normal dead-time sequence.

Top module: `hbridge_gate_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, all four gate outputs are 0.
- R2: The bridge is live only when `en_hi` is 1 and `en_lo_n` is 0. Any other combination drives all four gates to 0 within 4 clock cycles of the input change.
- R3: With the bridge live and no override, the gates settle as follows, written as (`pwm_a`,`pwm_b`). (1,0) is forward: leg A high side on and leg B low side on. (0,1) is reverse: leg A low side on and leg B high side on. (1,1) is short brake: both low sides on. (0,0) is coast: all four gates off.
- R4: No leg ever has its high-side and low-side gates at 1 in the same cycle.
- R5: After either switch of a leg turns off, both switches of that leg stay off for at least `DEAD_CYC` cycles before either turns on. A direct handover within one leg (for example high to low) has an off interval of exactly `DEAD_CYC` cycles.
- R6: A high-side gate turns on only in a cycle where the low-side gate of the opposite leg is on. A swap between forward and reverse therefore always passes through short brake.
- R7: When `force_off` is 1 at a clock edge, all four gates are 0 after that edge. No synchronizer and no dead-time delay apply.
- R8: While the bridge is live, `force_brake` is 1 and `force_off` is 0, both low-side gates settle on whatever the PWM inputs are. The dead interval of R5 still applies.
- R9: The overrides have a fixed priority. `force_off` overrides everything else. A disabled bridge overrides `force_brake`. `force_brake` overrides the PWM inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sequencer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_a | input | 1 | Direction input for leg A (asynchronous) |
| pwm_b | input | 1 | Direction input for leg B (asynchronous) |
| en_hi | input | 1 | Active-high bridge enable (asynchronous) |
| en_lo_n | input | 1 | Active-low bridge enable (asynchronous) |
| force_off | input | 1 | Protection request: all gates off at once (synchronous) |
| force_brake | input | 1 | Current-limit request: short brake (synchronous) |
| gate_hi_a | output | 1 | High-side gate command, leg A |
| gate_lo_a | output | 1 | Low-side gate command, leg A |
| gate_hi_b | output | 1 | High-side gate command, leg B |
| gate_lo_b | output | 1 | Low-side gate command, leg B |

## Verification
The bench targets direction reversals, brake to drive transitions and overrides that arrive in the middle of a dead interval. If the design got these wrong, it would either turn the opposite switch on early (the off run per leg would be shorter than `DEAD_CYC`) or jump straight from forward to reverse with no high side turning on over a braked opposite leg. It measures the exact off run of a high to low handover, so an off-by-one in the dead counter shows up. It also asserts `force_off` while a leg is waiting out its dead time, to catch a design that lets the pending turn-on complete anyway. It applies every enable combination together with `force_brake`, to catch a reversed priority that brakes a bridge that should be floating.

// File: rtl/hbridge_gate_seq.sv
module hbridge_gate_seq #(
  parameter int DEAD_CYC = 20,
  parameter int SYNC_LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_a,
  input  logic pwm_b,
  input  logic en_hi,
  input  logic en_lo_n,
  input  logic force_off,
  input  logic force_brake,
  output logic gate_hi_a,
  output logic gate_lo_a,
  output logic gate_hi_b,
  output logic gate_lo_b
);
  localparam int CW = $clog2(DEAD_CYC + 1);
  localparam logic [1:0] L_OFF = 2'd0;
  localparam logic [1:0] L_HI  = 2'd1;
  localparam logic [1:0] L_LO  = 2'd2;
  localparam logic [CW-1:0] DEAD_LOAD = CW'(DEAD_CYC - 1);

  logic [SYNC_LEN-1:0] sy_pa, sy_pb, sy_en, sy_enn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy_pa  <= '0;
      sy_pb  <= '0;
      sy_en  <= '0;
      sy_enn <= '1;
    end else begin
      sy_pa  <= {sy_pa[SYNC_LEN-2:0], pwm_a};
      sy_pb  <= {sy_pb[SYNC_LEN-2:0], pwm_b};
      sy_en  <= {sy_en[SYNC_LEN-2:0], en_hi};
      sy_enn <= {sy_enn[SYNC_LEN-2:0], en_lo_n};
    end
  end

  wire pa   = sy_pa[SYNC_LEN-1];
  wire pb   = sy_pb[SYNC_LEN-1];
  wire live = sy_en[SYNC_LEN-1] & ~sy_enn[SYNC_LEN-1];

  logic [1:0]    cur  [2];
  logic [1:0]    want [2];
  logic [1:0]    eff  [2];
  logic [CW-1:0] dcnt [2];

  always_comb begin
    if (force_off || !live) begin
      want[0] = L_OFF;
      want[1] = L_OFF;
    end else if (force_brake) begin
      want[0] = L_LO;
      want[1] = L_LO;
    end else begin
      unique case ({pa, pb})
        2'b10:   begin want[0] = L_HI;  want[1] = L_LO;  end
        2'b01:   begin want[0] = L_LO;  want[1] = L_HI;  end
        2'b11:   begin want[0] = L_LO;  want[1] = L_LO;  end
        default: begin want[0] = L_OFF; want[1] = L_OFF; end
      endcase
    end
    for (int i = 0; i < 2; i++) begin
      eff[i] = want[i];
      if (want[i] == L_HI && !(cur[1-i] == L_LO && want[1-i] == L_LO))
        eff[i] = (cur[i] == L_LO) ? L_LO : L_OFF;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        cur[i]  <= L_OFF;
        dcnt[i] <= '0;
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (eff[i] != cur[i] && cur[i] != L_OFF) begin
          cur[i]  <= L_OFF;
          dcnt[i] <= DEAD_LOAD;
        end else if (eff[i] != cur[i] && dcnt[i] == '0) begin
          cur[i] <= eff[i];
        end else if (dcnt[i] != '0) begin
          dcnt[i] <= dcnt[i] - 1'b1;
        end
      end
    end
  end

  assign gate_hi_a = (cur[0] == L_HI);
  assign gate_lo_a = (cur[0] == L_LO);
  assign gate_hi_b = (cur[1] == L_HI);
  assign gate_lo_b = (cur[1] == L_LO);

  // R4
  leg_a_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi_a && gate_lo_a));
  // R4
  leg_b_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi_b && gate_lo_b));
  // R5
  leg_a_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_hi_a) |-> $past(!gate_lo_a));
  // R5
  leg_b_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_lo_b) |-> $past(!gate_hi_b));
  // R6
  hi_a_brake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_hi_a) |-> gate_lo_b);
  // R6
  hi_b_brake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_hi_b) |-> gate_lo_a);
  // R7
  force_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_off |=> !(gate_hi_a || gate_lo_a || gate_hi_b || gate_lo_b));
endmodule

// File: tb/hbridge_gate_seq_tb.sv
module hbridge_gate_seq_tb_top;
  localparam int CLK_PER = 200;
  localparam int DEAD = 20;

  logic clk = 0, rst_n = 0;
  logic pwm_a = 0, pwm_b = 0, en_hi = 0, en_lo_n = 1, force_off = 0, force_brake = 0;
  logic gate_hi_a, gate_lo_a, gate_hi_b, gate_lo_b;
  int errors = 0, checks = 0;
  int offrun [2];
  logic mon_on = 0;

  hbridge_gate_seq #(.DEAD_CYC(DEAD), .SYNC_LEN(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwm_a(pwm_a), .pwm_b(pwm_b),
    .en_hi(en_hi), .en_lo_n(en_lo_n), .force_off(force_off),
    .force_brake(force_brake), .gate_hi_a(gate_hi_a), .gate_lo_a(gate_lo_a),
    .gate_hi_b(gate_hi_b), .gate_lo_b(gate_lo_b));

  always #(CLK_PER/2) clk = ~clk;

  function automatic logic [3:0] expect_gates(logic pa, logic pb, logic e, logic en_n,
                                              logic fo, logic fb);
    if (fo || !(e && !en_n)) return 4'b0000;
    if (fb) return 4'b0101;
    case ({pa, pb})
      2'b10:   return 4'b1001;
      2'b01:   return 4'b0110;
      2'b11:   return 4'b0101;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [3:0] gates();
    return {gate_hi_a, gate_lo_a, gate_hi_b, gate_lo_b};
  endfunction

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: gates=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // per-cycle monitor: R4 overlap, R5 gap, R6 brake-pass
  logic [3:0] prev_g = 4'b0000;
  always @(negedge clk) if (mon_on) begin
    logic [3:0] g;
    g = gates();
    for (int i = 0; i < 2; i++) begin
      logic hi, lo, phi, plo;
      hi = g[3-2*i]; lo = g[2-2*i]; phi = prev_g[3-2*i]; plo = prev_g[2-2*i];
      if (hi && lo) begin
        errors++; checks++;
        $display("FAIL R4: leg %0d hi=%b lo=%b expected no overlap", i, hi, lo);
      end
      if ((hi || lo) && !(phi || plo)) begin
        checks++;
        if (offrun[i] < DEAD) begin
          errors++;
          $display("FAIL R5: leg %0d off run=%0d expected>=%0d", i, offrun[i], DEAD);
        end
      end
      if (hi && !phi) begin
        checks++;
        if (!g[2-2*(1-i)]) begin
          errors++;
          $display("FAIL R6: leg %0d high on, other low=%b expected 1", i, g[2-2*(1-i)]);
        end
      end
      if (!(hi || lo)) offrun[i]++; else offrun[i] = 0;
    end
    prev_g = g;
  end

  initial begin
    #(CLK_PER * 190000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int seed;
    int run;
    seed = 1234;
    void'($urandom(seed));
    offrun[0] = 1000; offrun[1] = 1000;
    cyc(3);
    chk("R1 in reset", gates(), 4'b0000);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset", gates(), 4'b0000);
    mon_on = 1;

    // R2: disabled with forward request stays off
    pwm_a = 1; cyc(60);
    chk("R2 disabled", gates(), 4'b0000);
    en_hi = 1; cyc(60);
    chk("R2 en_lo_n high", gates(), 4'b0000);
    en_lo_n = 0; cyc(60);
    chk("R3 forward", gates(), 4'b1001);

    // R5: exact handover forward -> brake on leg A
    pwm_b = 1;
    while (!(gate_hi_a == 0 && gate_lo_a == 0)) @(negedge clk);
    run = 0;
    while (!gate_lo_a) begin run++; @(negedge clk); end
    checks++;
    if (run != DEAD) begin
      errors++;
      $display("FAIL R5: handover off run=%0d expected=%0d", run, DEAD);
    end
    cyc(40);
    chk("R3 brake", gates(), 4'b0101);

    // R6/R3: reverse via brake
    pwm_a = 0; cyc(80);
    chk("R3 reverse", gates(), 4'b0110);
    pwm_a = 1; pwm_b = 0; cyc(80);
    chk("R6 reversal back to forward", gates(), 4'b1001);

    // R7: force_off during a pending dead interval
    pwm_a = 0; pwm_b = 1; cyc(5);
    force_off = 1; cyc(1);
    chk("R7 force_off", gates(), 4'b0000);
    cyc(DEAD + 5);
    chk("R7 force_off held", gates(), 4'b0000);
    force_brake = 1; cyc(2);
    chk("R9 force_off over brake", gates(), 4'b0000);
    force_off = 0; cyc(60);
    chk("R8 force_brake", gates(), 4'b0101);

    // R2: disable latency with brake requested
    en_hi = 0; cyc(4);
    chk("R2 disable latency", gates(), 4'b0000);
    cyc(30);
    chk("R9 disable over brake", gates(), 4'b0000);
    en_hi = 1; force_brake = 0; cyc(60);
    chk("R3 reverse after enable", gates(), 4'b0110);
    pwm_b = 0; cyc(4);
    chk("R3 coast", gates(), 4'b0000);

    // random segments
    for (int k = 0; k < 250; k++) begin
      logic [3:0] e;
      int hold;
      pwm_a = 1'($urandom); pwm_b = 1'($urandom);
      en_hi = ($urandom % 8) != 0; en_lo_n = ($urandom % 8) == 0;
      force_brake = ($urandom % 6) == 0;
      force_off = ($urandom % 10) == 0;
      hold = 1 + ($urandom % 30);
      cyc(hold);
      if (force_off) chk("R7 random force_off", gates(), 4'b0000);
      cyc(3 * DEAD + 10 - hold < 0 ? 0 : 3 * DEAD + 10 - hold + 20);
      e = expect_gates(pwm_a, pwm_b, en_hi, en_lo_n, force_off, force_brake);
      chk(force_brake ? "R8 R9 random settle" : "R2 R3 random settle", gates(), e);
    end

    mon_on = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule